// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block keeps the timing state of every bank in a set of DRAM ranks so that a command scheduler can ask, in any cycle, which commands are currently legal. For each bank it stores the open row and three earliest-allowed timestamps. The first timestamp gates column commands, the second gates closing the row and the third gates opening a new row. It also tracks how many column accesses the current row has received. For each rank it keeps a short history of recent row openings, so that it can enforce both a minimum gap between openings and a cap on how many openings fall inside a sliding window.

The scheduler drives a free-running cycle count on `now`. It issues at most one command per cycle through `cmd_valid`, `cmd_op`, `cmd_rank`, `cmd_bank` and `cmd_row`. The tracker records the command at the clock edge. All legality flags are derived combinationally from the stored timestamps and the current value of `now`, so a flag rises in exactly the cycle in which the counter reaches the stored limit. When a row has received the configured number of column accesses, the tracker raises a close request for that bank and withholds further column permission until the row is closed.

Top module: `dram_bank_tracker`

## Requirements
- R1: Each bank holds an open-row value, and the all-ones value means that no row is open. An activate loads the supplied row, and a precharge restores the all-ones value. The value is visible on `open_row` from the cycle after the command.
- R2: After reset, every bank reports no open row, `act_ok` high, `col_ok` low, `pre_ok` low and `force_close` low.
- R3: For an activate recorded while `now` equals t, `col_ok` of that bank is low while `now` < t+T_RCD and high from t+T_RCD. `pre_ok` is low while `now` < t+T_RAS and high from t+T_RAS. `act_ok` is low for any bank whose row is open.
- R4: For a precharge recorded at time t, `act_ok` of that bank is low while `now` < t+T_RP and high from t+T_RP, provided that the rank limits also allow it.
- R5: Activates within one rank are spaced by at least T_RRD. After an activate at time t, `act_ok` of every bank in that rank is low until `now` reaches t+T_RRD. Other ranks are unaffected.
- R6: A rank accepts at most ACT_LIMIT activates in any T_XAW window. Once ACT_LIMIT activates are recorded, the rank's `act_ok` stays low until `now` reaches the oldest of them plus T_XAW.
- R7: Each bank counts the reads and writes it receives since its row was opened. When the count reaches MAX_ROW_ACC, `force_close` goes high and `col_ok` goes low. Both `force_close` and the count clear when the bank is precharged.
- R8: Command encoding on `cmd_op` is 0 for activate, 1 for read, 2 for write and 3 for precharge. A bank's flag bit index is rank*BANKS_PER_RANK+bank, and its open-row field occupies bits [index*ROW_W +: ROW_W] of `open_row`.
- R9: A read at time t holds the bank's `pre_ok` low until the later of its earlier limit and t+T_RTP. It holds `col_ok` low until the later of its earlier limit and t+T_BURST.
- R10: A write at time t holds the bank's `pre_ok` low until the later of its earlier limit and t+T_BURST+T_WR. It holds `col_ok` low until the later of its earlier limit and t+T_BURST.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TIME_W | Cycle counter supplied by the scheduler |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | Command kind (0 activate, 1 read, 2 write, 3 precharge) |
| cmd_rank | input | clog2(NUM_RANKS) | Target rank |
| cmd_bank | input | clog2(BANKS_PER_RANK) | Target bank within the rank |
| cmd_row | input | ROW_W | Row for an activate |
| col_ok | output | NUM_RANKS*BANKS_PER_RANK | Column command legal, per bank |
| pre_ok | output | NUM_RANKS*BANKS_PER_RANK | Precharge legal, per bank |
| act_ok | output | NUM_RANKS*BANKS_PER_RANK | Activate legal, per bank |
| force_close | output | NUM_RANKS*BANKS_PER_RANK | Row reached its access cap and must be closed |
| open_row | output | NUM_RANKS*BANKS_PER_RANK*ROW_W | Open row per bank, all ones when closed |

## Verification
The assertions rely on two properties of the inputs. First, `now` advances by exactly one per clock from zero at reset and never wraps. Second, the scheduler issues only commands whose flag is currently high, and every timing parameter is at least 2. The stimulus meets both conditions: the bench drives `now` from its own counter, and it waits until the relevant timestamp has been reached before each command. Under these conditions, a freshly issued activate or precharge always blocks the next cycle's column or activate permission, and the activate history grows by one per accepted activate until it fills.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } dbt_op_e;
endpackage

// File: rtl/dbt_act_window.sv
module dbt_act_window
    import dbt_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int T_RRD     = 2,
    parameter int T_XAW     = 20,
    parameter int ACT_LIMIT = 4,
    localparam int PTR_W    = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              act_fire,
    output logic              act_allowed
);
    typedef struct packed {
        logic [ACT_LIMIT-1:0][TIME_W-1:0] stamp;
        logic [ACT_LIMIT-1:0]             used;
        logic [PTR_W-1:0]                 wr;
        logic [TIME_W-1:0]                last;
        logic                             seen;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    rrd_ok, xaw_ok;

    always_comb begin
        st_d = st_q;
        if (act_fire) begin
            st_d.stamp[st_q.wr] = now;
            st_d.used[st_q.wr]  = 1'b1;
            st_d.wr   = (st_q.wr == PTR_W'(ACT_LIMIT - 1)) ? '0 : st_q.wr + 1'b1;
            st_d.last = now;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The slot at the write pointer holds the oldest stamp once the ring is full.
    assign rrd_ok      = !st_q.seen || (now >= st_q.last + TIME_W'(T_RRD));
    assign xaw_ok      = !st_q.used[st_q.wr] || (now >= st_q.stamp[st_q.wr] + TIME_W'(T_XAW));
    assign act_allowed = rrd_ok && xaw_ok;

    // R5
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> (T_RRD < 2) || !act_allowed);

    // R6
    hist_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> ($countones(st_q.used) == ACT_LIMIT) ||
                     ($countones(st_q.used) == $countones($past(st_q.used)) + 1));
endmodule

// File: rtl/dbt_bank.sv
module dbt_bank
    import dbt_pkg::*;
#(
    parameter int ROW_W       = 8,
    parameter int TIME_W      = 32,
    parameter int T_RCD       = 3,
    parameter int T_RAS       = 8,
    parameter int T_RP        = 3,
    parameter int T_RTP       = 2,
    parameter int T_WR        = 4,
    parameter int T_BURST     = 2,
    parameter int MAX_ROW_ACC = 4,
    localparam int CNT_W      = $clog2(MAX_ROW_ACC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              hit,
    input  dbt_op_e           op,
    input  logic [ROW_W-1:0]  row_in,
    input  logic              rank_act_ok,
    output logic              col_ok,
    output logic              pre_ok,
    output logic              act_ok,
    output logic              force_close,
    output logic [ROW_W-1:0]  open_row
);
    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [TIME_W-1:0] col_at;
        logic [TIME_W-1:0] pre_at;
        logic [TIME_W-1:0] act_at;
        logic [CNT_W-1:0]  acc;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     is_open;

    function automatic logic [TIME_W-1:0] later(input logic [TIME_W-1:0] a,
                                                input logic [TIME_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_comb begin
        st_d = st_q;
        if (hit) begin
            unique case (op)
                OP_ACT: begin
                    st_d.row    = row_in;
                    st_d.col_at = now + TIME_W'(T_RCD);
                    st_d.pre_at = now + TIME_W'(T_RAS);
                    st_d.acc    = '0;
                end
                OP_RD: begin
                    st_d.col_at = later(st_q.col_at, now + TIME_W'(T_BURST));
                    st_d.pre_at = later(st_q.pre_at, now + TIME_W'(T_RTP));
                    if (st_q.acc != CNT_W'(MAX_ROW_ACC)) st_d.acc = st_q.acc + 1'b1;
                end
                OP_WR: begin
                    st_d.col_at = later(st_q.col_at, now + TIME_W'(T_BURST));
                    st_d.pre_at = later(st_q.pre_at, now + TIME_W'(T_BURST + T_WR));
                    if (st_q.acc != CNT_W'(MAX_ROW_ACC)) st_d.acc = st_q.acc + 1'b1;
                end
                OP_PRE: begin
                    st_d.row    = '1;
                    st_d.act_at = now + TIME_W'(T_RP);
                    st_d.acc    = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.row    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign is_open     = (st_q.row != '1);
    assign force_close = is_open && (st_q.acc == CNT_W'(MAX_ROW_ACC));
    assign col_ok      = is_open && !force_close && (now >= st_q.col_at);
    assign pre_ok      = is_open && (now >= st_q.pre_at);
    assign act_ok      = !is_open && rank_act_ok && (now >= st_q.act_at);
    assign open_row    = st_q.row;

    // R1
    open_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_ACT) |=> open_row == $past(row_in));

    // R1
    close_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_PRE) |=> open_row == '1);

    // R3
    act_col_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_ACT) |=> (T_RCD < 2) || !col_ok);

    // R4
    pre_act_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_PRE) |=> (T_RP < 2) || !act_ok);

    // R7
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_close |=> force_close || $past(hit && (op == OP_PRE || op == OP_ACT)));
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
    import dbt_pkg::*;
#(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 4,
    parameter int ROW_W          = 8,
    parameter int TIME_W         = 32,
    parameter int T_RCD          = 3,
    parameter int T_RAS          = 8,
    parameter int T_RP           = 3,
    parameter int T_RRD          = 2,
    parameter int T_XAW          = 20,
    parameter int ACT_LIMIT      = 4,
    parameter int T_RTP          = 2,
    parameter int T_WR           = 4,
    parameter int T_BURST        = 2,
    parameter int MAX_ROW_ACC    = 4,
    localparam int NUM_BANKS     = NUM_RANKS * BANKS_PER_RANK,
    localparam int RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W        = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TIME_W-1:0]          now,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [RANK_W-1:0]          cmd_rank,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    output logic [NUM_BANKS-1:0]       col_ok,
    output logic [NUM_BANKS-1:0]       pre_ok,
    output logic [NUM_BANKS-1:0]       act_ok,
    output logic [NUM_BANKS-1:0]       force_close,
    output logic [NUM_BANKS*ROW_W-1:0] open_row
);
    dbt_op_e              op_e;
    logic [NUM_BANKS-1:0] hit_vec;
    logic [NUM_RANKS-1:0] rank_ok;

    assign op_e = dbt_op_e'(cmd_op);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic rank_hit;
        assign rank_hit = cmd_valid && (cmd_rank == RANK_W'(r));

        dbt_act_window #(
            .TIME_W    (TIME_W),
            .T_RRD     (T_RRD),
            .T_XAW     (T_XAW),
            .ACT_LIMIT (ACT_LIMIT)
        ) u_win (
            .clk         (clk),
            .rst_n       (rst_n),
            .now         (now),
            .act_fire    (rank_hit && op_e == OP_ACT),
            .act_allowed (rank_ok[r])
        );

        for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
            localparam int IDX = r * BANKS_PER_RANK + b;
            assign hit_vec[IDX] = rank_hit && (cmd_bank == BANK_W'(b));

            dbt_bank #(
                .ROW_W       (ROW_W),
                .TIME_W      (TIME_W),
                .T_RCD       (T_RCD),
                .T_RAS       (T_RAS),
                .T_RP        (T_RP),
                .T_RTP       (T_RTP),
                .T_WR        (T_WR),
                .T_BURST     (T_BURST),
                .MAX_ROW_ACC (MAX_ROW_ACC)
            ) u_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .now         (now),
                .hit         (hit_vec[IDX]),
                .op          (op_e),
                .row_in      (cmd_row),
                .rank_act_ok (rank_ok[r]),
                .col_ok      (col_ok[IDX]),
                .pre_ok      (pre_ok[IDX]),
                .act_ok      (act_ok[IDX]),
                .force_close (force_close[IDX]),
                .open_row    (open_row[IDX*ROW_W +: ROW_W])
            );
        end
    end

    // R8
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5
    rank_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_e == OP_ACT) |=> (T_RRD < 2) ||
            !(act_ok[$past(cmd_rank) * BANKS_PER_RANK +: BANKS_PER_RANK] != '0));
endmodule

// File: tb/tb_dram_bank_tracker.sv
`timescale 1ns/1ps
module tb_dram_bank_tracker;
    localparam int NR = 2, BPR = 4, RW = 8, TW = 32;
    localparam int T_RCD = 3, T_RAS = 8, T_RP = 3, T_RRD = 2, T_XAW = 20;
    localparam int T_RTP = 2, T_WR = 4, T_BURST = 2, MAXA = 4;
    localparam int NB = NR * BPR;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TW-1:0] now;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [0:0] cmd_rank = '0;
    logic [1:0] cmd_bank = '0;
    logic [RW-1:0] cmd_row = '0;
    logic [NB-1:0] col_ok, pre_ok, act_ok, force_close;
    logic [NB*RW-1:0] open_row;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1;
    end

    dram_bank_tracker #(
        .NUM_RANKS(NR), .BANKS_PER_RANK(BPR), .ROW_W(RW), .TIME_W(TW),
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RRD(T_RRD), .T_XAW(T_XAW),
        .ACT_LIMIT(4), .T_RTP(T_RTP), .T_WR(T_WR), .T_BURST(T_BURST), .MAX_ROW_ACC(MAXA)
    ) dut (
        .clk(clk), .rst_n(rst_n), .now(now), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .col_ok(col_ok), .pre_ok(pre_ok), .act_ok(act_ok),
        .force_close(force_close), .open_row(open_row)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at now=%0d: actual=%0h expected=%0h", req, what, now, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] row_of(input int idx);
        return open_row[idx*RW +: RW];
    endfunction

    task automatic goto(input int t);
        while (int'(now) < t) @(negedge clk);
    endtask

    // Issues one command for one cycle; t is the counter value it is recorded at.
    task automatic issue(input logic [1:0] op, input int r, input int b,
                         input logic [RW-1:0] row, output int t);
        cmd_valid = 1'b1; cmd_op = op; cmd_rank = 1'(r); cmd_bank = 2'(b); cmd_row = row;
        t = int'(now);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic test_reset();
        chk("R2", "act_ok", act_ok, {NB{1'b1}});
        chk("R2", "col_ok", col_ok, '0);
        chk("R2", "pre_ok", pre_ok, '0);
        chk("R2", "force_close", force_close, '0);
        for (int i = 0; i < NB; i++) chk("R1", "open_row closed", row_of(i), 8'hFF);
    endtask

    task automatic test_act_rd_wr_pre();
        int t, m, w, p;
        issue(2'd0, 0, 0, 8'h05, t);
        chk("R1", "open_row b0", row_of(0), 8'h05);
        chk("R3", "act_ok open bank", act_ok[0], 1'b0);
        goto(t + T_RCD - 1); chk("R3", "col_ok early", col_ok[0], 1'b0);
        goto(t + T_RCD);     chk("R3", "col_ok at tRCD", col_ok[0], 1'b1);
        goto(t + T_RAS - 1); chk("R3", "pre_ok early", pre_ok[0], 1'b0);
        goto(t + T_RAS);     chk("R3", "pre_ok at tRAS", pre_ok[0], 1'b1);
        issue(2'd1, 0, 0, '0, m);
        chk("R9", "pre_ok after read", pre_ok[0], 1'b0);
        chk("R9", "col_ok after read", col_ok[0], 1'b0);
        goto(m + T_RTP); chk("R9", "pre_ok at tRTP", pre_ok[0], 1'b1);
        chk("R9", "col_ok at burst", col_ok[0], 1'b1);
        issue(2'd2, 0, 0, '0, w);
        chk("R10", "col_ok after write", col_ok[0], 1'b0);
        goto(w + T_BURST); chk("R10", "col_ok at burst", col_ok[0], 1'b1);
        goto(w + T_BURST + T_WR - 1); chk("R10", "pre_ok early", pre_ok[0], 1'b0);
        goto(w + T_BURST + T_WR);     chk("R10", "pre_ok at burst+tWR", pre_ok[0], 1'b1);
        issue(2'd3, 0, 0, '0, p);
        chk("R1", "open_row after pre", row_of(0), 8'hFF);
        goto(p + T_RP - 1); chk("R4", "act_ok early", act_ok[0], 1'b0);
        goto(p + T_RP);     chk("R4", "act_ok at tRP", act_ok[0], 1'b1);
    endtask

    task automatic test_row_cap();
        int t, q;
        goto(int'(now) + 25);
        issue(2'd0, 0, 1, 8'h21, q);
        goto(q + T_RCD);
        for (int k = 0; k < MAXA; k++) begin
            chk("R7", "force_close before cap", force_close[1], 1'b0);
            issue(2'd1, 0, 1, '0, t);
            goto(t + T_BURST);
        end
        chk("R7", "force_close at cap", force_close[1], 1'b1);
        chk("R7", "col_ok blocked at cap", col_ok[1], 1'b0);
        goto(q + T_RAS + 4);
        issue(2'd3, 0, 1, '0, t);
        chk("R7", "force_close cleared", force_close[1], 1'b0);
    endtask

    task automatic test_rank_limits();
        int a, t;
        goto(int'(now) + 30);
        issue(2'd0, 1, 0, 8'h40, a);
        chk("R8", "open_row rank1 bank0", row_of(4), 8'h40);
        chk("R8", "rank0 bank0 untouched", row_of(0), 8'hFF);
        chk("R5", "act_ok same rank in gap", act_ok[5], 1'b0);
        chk("R5", "act_ok other rank", act_ok[2], 1'b1);
        goto(a + T_RRD); chk("R5", "act_ok after tRRD", act_ok[5], 1'b1);
        issue(2'd0, 1, 1, 8'h41, t);
        goto(a + 2 * T_RRD); issue(2'd0, 1, 2, 8'h42, t);
        goto(a + 3 * T_RRD); issue(2'd0, 1, 3, 8'h43, t);
        goto(a + T_RAS); issue(2'd3, 1, 0, '0, t);
        goto(a + T_XAW - 1);
        chk("R6", "act_ok window full", act_ok[4], 1'b0);
        chk("R6", "other rank free", act_ok[2], 1'b1);
        goto(a + T_XAW);
        chk("R6", "act_ok window slid", act_ok[4], 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_act_rd_wr_pre();
        test_row_cap();
        test_rank_limits();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule